// File: doc/BRIEF.md
# Partial timestamp reconstructor

Frame timestamp units often keep only the low bits of the free-running tick counter when a frame enters or leaves a port. That saves storage but leaves a value that wraps: 24 bits of 8 ns ticks wrap in roughly 0.135 s, and 32 bits in roughly 34.35 s. This block rebuilds the full 64-bit timestamp. It takes the truncated capture and a full reading of the same counter taken later. The upper bits come from the later reading. When the reading's low bits show that the counter has wrapped since the capture, one wrap period is taken off.

A producer presents a partial value and the current time with a valid/ready handshake. The reconstructed value appears one clock later behind a valid/ready output, together with a flag that tells whether the wrap correction was applied. The result is correct only if the current-time reading is taken less than one wrap period after the capture. Meeting that bound is the caller's job.

Top module: `ts_recon`

## Requirements
- R1: The partial width `TS_W` is 24 or 32, and any other value stops elaboration. The block handles the low `TS_W` bits of a 64-bit tick count.
- R2: `in_ready_o` is high exactly when the output register is empty or `out_ready_i` is high. An input is taken on a clock edge where both `in_valid_i` and `in_ready_o` are high.
- R3: An input taken at a clock edge makes `out_valid_o` high after that same edge, with its result on `out_ts_o`. This gives one cycle of latency.
- R4: Bits `[TS_W-1:0]` of `out_ts_o` equal the partial value that was taken.
- R5: When the low `TS_W` bits of the current time are strictly greater than the partial value, bits `[63:TS_W]` of the result equal those of the current time.
- R6: When the low `TS_W` bits of the current time are less than or equal to the partial value, including equality, the result is the current time with its low bits replaced by the partial value, minus 2^TS_W.
- R7: The subtraction is modulo 2^64. If the upper bits of the current time are zero and a correction applies, the result wraps to the top of the 64-bit range.
- R8: `out_wrap_o` is high with a result exactly when the correction of R6 was applied to it.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_ts_o` and `out_wrap_o` hold their values and no new input is taken.
- R10: While `rst_ni` is low, `out_valid_o` is low and `in_ready_o` is high.
- R11: With `out_ready_i` held high, an input can be taken on every cycle, and each one yields its own result on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input request present |
| in_ready_o | output | 1 | Block can take an input |
| in_partial_i | input | TS_W | Truncated capture of the tick counter |
| in_now_i | input | 64 | Later full reading of the tick counter |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| out_ts_o | output | 64 | Reconstructed 64-bit timestamp |
| out_wrap_o | output | 1 | One wrap period was subtracted |

## Verification
On every cycle the assertions check four things. A taken input turns into a valid result on the next cycle. A stalled result stays put. The low bits of the result match the captured value. The distance from the current-time reading back to the result lies between 1 and 2^TS_W ticks, and the wrap flag matches whether the upper bits differ from the reading's. Other properties need the bench's scenarios, which run both widths. These are the exact choice of correction at the equality boundary (low bits equal to the partial value, all-zero and all-ones cases), the modulo-2^64 result when the reading's upper bits are zero, and the order of results under backpressure.

// File: rtl/ts_recon_pkg.sv
package ts_recon_pkg;
  localparam int unsigned TIME_W = 64;
  typedef logic [TIME_W-1:0] tick_t;
  typedef struct packed {
    tick_t ts;
    logic  wrap;
  } recon_t;
  localparam int unsigned RECON_W = $bits(recon_t);
endpackage

// File: rtl/ts_wrap_detect.sv
module ts_wrap_detect #(
  parameter int unsigned TS_W = 32
) (
  input  logic [TS_W-1:0] now_low_i,
  input  logic [TS_W-1:0] partial_i,
  output logic            wrap_o
);
  // equal low bits means a full period elapsed, not zero time
  assign wrap_o = (now_low_i <= partial_i);
endmodule

// File: rtl/ts_splice.sv
module ts_splice import ts_recon_pkg::*; #(
  parameter int unsigned TS_W = 32
) (
  input  tick_t           now_i,
  input  logic [TS_W-1:0] partial_i,
  input  logic            wrap_i,
  output recon_t          res_o
);
  localparam int unsigned UP_W = TIME_W - TS_W;

  logic [UP_W-1:0] upper;
  logic [UP_W-1:0] upper_adj;

  assign upper = now_i[TIME_W-1:TS_W];
  // subtracting 2^TS_W only touches the upper field (modulo 2^64)
  assign upper_adj = upper - {{(UP_W-1){1'b0}}, wrap_i};

  always_comb begin
    res_o.ts   = {upper_adj, partial_i};
    res_o.wrap = wrap_i;
  end
endmodule

// File: rtl/ts_out_stage.sv
module ts_out_stage #(
  parameter int unsigned DATA_W = 65
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end
endmodule

// File: rtl/ts_recon.sv
module ts_recon import ts_recon_pkg::*; #(
  parameter int unsigned TS_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [TS_W-1:0]   in_partial_i,
  input  logic [TIME_W-1:0] in_now_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [TIME_W-1:0] out_ts_o,
  output logic              out_wrap_o
);
  if (!(TS_W == 24 || TS_W == 32)) begin : g_bad_width
    $error("ts_recon: TS_W must be 24 or 32");
  end

  logic   wrap;
  recon_t res_d;
  recon_t res_q;

  ts_wrap_detect #(.TS_W(TS_W)) u_wrap (
    .now_low_i (in_now_i[TS_W-1:0]),
    .partial_i (in_partial_i),
    .wrap_o    (wrap)
  );

  ts_splice #(.TS_W(TS_W)) u_splice (
    .now_i     (in_now_i),
    .partial_i (in_partial_i),
    .wrap_i    (wrap),
    .res_o     (res_d)
  );

  ts_out_stage #(.DATA_W(RECON_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (res_d),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (res_q)
  );

  assign out_ts_o   = res_q.ts;
  assign out_wrap_o = res_q.wrap;
endmodule

// File: rtl/ts_recon_chk.sv
module ts_recon_chk import ts_recon_pkg::*; #(
  parameter int unsigned TS_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [TS_W-1:0]   in_partial_i,
  input logic [TIME_W-1:0] in_now_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [TIME_W-1:0] out_ts_o,
  input logic              out_wrap_o
);
  localparam logic [TIME_W-1:0] PERIOD = TIME_W'(1) << TS_W;

  logic              take;
  logic [TIME_W-1:0] now_q;
  logic [TS_W-1:0]   part_q;
  logic [TIME_W-1:0] gap;

  assign take = in_valid_i && in_ready_o;
  assign gap  = now_q - out_ts_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q  <= '0;
      part_q <= '0;
    end else if (take) begin
      now_q  <= in_now_i;
      part_q <= in_partial_i;
    end
  end

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> out_valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_ts_o) && $stable(out_wrap_o)));

  p_no_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_low_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_ts_o[TS_W-1:0] == part_q));

  p_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (gap != '0 && gap <= PERIOD));

  p_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_wrap_o == (out_ts_o[TIME_W-1:TS_W] != now_q[TIME_W-1:TS_W])));
endmodule

bind ts_recon ts_recon_chk #(.TS_W(TS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .in_partial_i (in_partial_i),
  .in_now_i     (in_now_i),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_ts_o     (out_ts_o),
  .out_wrap_o   (out_wrap_o)
);

// File: tb/tb_ts_recon.sv
module tb_ts_recon;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic [63:0] now = '0;
  logic [31:0] part = '0;

  logic        rdy [2];
  logic        ov [2];
  logic [63:0] ots [2];
  logic        owr [2];

  int checks = 0;
  int errors = 0;
  bit stream = 0;

  always #(CLK_NS/2) clk = ~clk;

  ts_recon #(.TS_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy[0]),
    .in_partial_i(part), .in_now_i(now), .out_valid_o(ov[0]),
    .out_ready_i(out_ready), .out_ts_o(ots[0]), .out_wrap_o(owr[0]));

  ts_recon #(.TS_W(24)) dut_w24 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy[1]),
    .in_partial_i(part[23:0]), .in_now_i(now), .out_valid_o(ov[1]),
    .out_ready_i(out_ready), .out_ts_o(ots[1]), .out_wrap_o(owr[1]));

  int unsigned width [2] = '{32, 24};

  // reference model state
  bit              exp_v [2];
  longint unsigned exp_ts [2];
  bit              exp_wr [2];
  longint unsigned exp_lo [2];
  string           exp_tag [2];

  task automatic check(string tag, longint unsigned act, longint unsigned exp, int inst);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s w%0d actual=%h expected=%h", tag, width[inst], act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) exp_v[i] <= 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        longint unsigned m, lo, pv, r;
        bit w;
        m  = 64'd1 << width[i];
        pv = longint'(part) % m;
        lo = now % m;
        w  = (lo <= pv);
        r  = now - lo + pv;
        if (w) r = r - m;
        if (!exp_v[i] || out_ready) begin
          exp_v[i] <= in_valid;
          if (in_valid) begin
            exp_ts[i] <= r;
            exp_wr[i] <= w;
            exp_lo[i] <= pv;
            if (w && (now >> width[i]) == 0) exp_tag[i] <= "R7";
            else if (w)                      exp_tag[i] <= "R6";
            else                             exp_tag[i] <= "R5";
          end
        end else begin
          exp_tag[i] <= "R9";
        end
      end
    end
  end

  always @(negedge clk) begin
    #(CLK_NS/4);
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        check("R2", rdy[i], (!exp_v[i] || out_ready), i);
        check(stream ? "R11" : "R3", ov[i], exp_v[i], i);
        if (exp_v[i] && ov[i]) begin
          check(exp_tag[i], ots[i], exp_ts[i], i);
          check("R1/R4", ots[i] % (64'd1 << width[i]), exp_lo[i], i);
          check("R8", owr[i], exp_wr[i], i);
        end
      end
    end
  end

  task automatic send(longint unsigned n, int unsigned p);
    @(negedge clk);
    in_valid = 1'b1;
    now = n;
    part = p;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_NS/4);
    for (int i = 0; i < 2; i++) begin
      check("R10", ov[i], 0, i);
      check("R10", rdy[i], 1, i);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R5: no wrap
    send(64'h0000_0012_3456_789A, 32'h1000_0000);
    idle(2);
    // R6: equal low bits
    send(64'h0000_00AB_CDEF_0123, 32'hCDEF_0123);
    idle(1);
    // R6: low bits below partial
    send(64'h0000_0005_0000_0010, 32'hFFFF_FF00);
    idle(1);
    // R7: upper bits zero with correction
    send(64'h0000_0000_0000_0005, 32'h0000_0010);
    idle(1);
    send(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
    send(64'h0000_0007_0000_0000, 32'h0000_0000);
    idle(2);
    // R9: backpressure
    @(negedge clk); out_ready = 1'b0;
    in_valid = 1'b1; now = 64'h0000_0100_2000_0000; part = 32'h1000_0000;
    send(64'h0000_0200_0000_0001, 32'h0000_0001);
    send(64'h0000_0200_0000_0001, 32'h0000_0001);
    send(64'h0000_0200_0000_0001, 32'h0000_0001);
    @(negedge clk); out_ready = 1'b1;
    idle(3);
    // R11: back-to-back stream
    stream = 1;
    for (int k = 0; k < 60; k++)
      send({$urandom, $urandom}, $urandom);
    idle(2);
    stream = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      in_valid  = ($urandom % 3) != 0;
      out_ready = ($urandom % 2) != 0;
      now  = {$urandom, $urandom};
      part = (k % 4 == 0) ? now[31:0] : $urandom;
    end
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule